// File: doc/BRIEF.md
# Early-User-Mode Sync Word Padder

This block finishes a parallel configuration load. After the image itself has been streamed, the target device may still need extra clock edges before it reports early user mode. On a start pulse the block reads the current clock-to-data ratio value, stores it, and writes the 1:1 ratio in its place. It then offers all-ones filler words on a valid/ready port one at a time, and leaves a fixed gap of idle cycles after each word so the status flag can settle.

Before each word the block looks at the early-user-mode input. Padding ends when that flag is seen or when a cycle budget, counted from the start pulse, runs out. In both cases the block writes the stored ratio back, raises done for one cycle with an error bit, and holds the number of filler words that were accepted until the next start. The default budget is 200,000,000 cycles, which is one second at 200 MHz.

Top module: `sync_pad_filler`

## Requirements
- R1: In the cycle where start is sampled in idle, the block stores ratioIn and drives ratioWrEn high with ratioWr equal to the 1:1 code (RATIO_ONE, default 0).
- R2: From the start cycle until done, the only ratio write is the 1:1 code, so the ratio register holds 1:1 throughout padding.
- R3: Every offered word is DATA_W bits of all ones. wordValid stays high, with wordData unchanged, until wordReady is seen.
- R4: The flag is examined before each word. If it is already high when padding starts, no word is offered and done rises in the cycle after the start cycle.
- R5: After each accepted word, wordValid stays low for GAP_CYCLES+1 cycles (the gap plus one check cycle). With wordReady held high, accepted words are therefore GAP_CYCLES+2 cycles apart.
- R6: A check cycle that finds the timer at TIMEOUT_CYCLES (counted from the start cycle), or a stalled offer at that count, ends padding with timedOut=1 and done in the following cycle. If the flag and the limit are seen in the same check cycle, the flag wins and timedOut=0.
- R7: In the done cycle, ratioWrEn is high and ratioWr carries the stored ratio. This holds for both success and timeout.
- R8: padCount is cleared at start, rises by one for each accepted word, and holds its value after done until the next start.
- R9: done is high for exactly one cycle per run. timedOut is valid in that same cycle.
- R10: A synchronous rst returns the block to idle and clears padCount, done, wordValid and ratioWrEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin padding (used only when idle) |
| done | output | 1 | One-cycle end-of-run pulse |
| timedOut | output | 1 | Run ended by timeout; valid with done |
| ratioIn | input | RATIO_W | Current clock-to-data ratio value |
| ratioWr | output | RATIO_W | Ratio value to write |
| ratioWrEn | output | 1 | Write strobe for ratioWr |
| wordData | output | DATA_W | Filler word |
| wordValid | output | 1 | Filler word offered |
| wordReady | input | 1 | Consumer accepts the word |
| earlyUser | input | 1 | Early-user-mode status from the device |
| padCount | output | CNT_W | Number of filler words accepted |

## Verification
The status flag and the expiry of the cycle budget can both be seen in the same check cycle. To force this, the bench holds wordReady high so that check cycles fall every GAP_CYCLES+2 cycles, and it sets the budget to an exact multiple of that spacing. It raises the flag just after the last word before the limit is accepted. The run passes only if done arrives with timedOut low and the word count has not changed. A separate run with the flag never raised confirms that the same check cycle reports a timeout.

// File: rtl/pad_pkg.sv
package pad_pkg;
  typedef enum logic [2:0] {
    PAD_IDLE,
    PAD_CHECK,
    PAD_SEND,
    PAD_GAP,
    PAD_FIN
  } padState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // store ratio, clear counters
    logic run;        // block busy, timer advances
    logic countWord;  // a filler word was accepted
    logic gapRun;     // gap counter advances
    logic restore;    // select stored ratio for write-back
  } padStrobe_t;
endpackage

// File: rtl/pad_ctrl.sv
module pad_ctrl
  import pad_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       earlyUser,
  input  logic       wordReady,
  input  logic       expired,
  input  logic       gapDone,
  output padStrobe_t strobe,
  output logic       wordValid,
  output logic       done,
  output logic       timedOut
);
  padState_t state, stateNext;
  logic errReg, errNext;

  always_comb begin
    stateNext = state;
    errNext   = errReg;
    strobe    = '0;
    wordValid = 1'b0;
    done      = 1'b0;
    strobe.run = (state != PAD_IDLE);
    unique case (state)
      PAD_IDLE: if (start) begin
        strobe.capture = 1'b1;
        errNext        = 1'b0;
        stateNext      = PAD_CHECK;
      end
      PAD_CHECK: begin
        if (earlyUser) begin
          errNext   = 1'b0;
          stateNext = PAD_FIN;
        end else if (expired) begin
          errNext   = 1'b1;
          stateNext = PAD_FIN;
        end else begin
          stateNext = PAD_SEND;
        end
      end
      PAD_SEND: begin
        wordValid = 1'b1;
        if (wordReady) begin
          strobe.countWord = 1'b1;
          stateNext        = PAD_GAP;
        end else if (expired) begin
          errNext   = 1'b1;
          stateNext = PAD_FIN;
        end
      end
      PAD_GAP: begin
        strobe.gapRun = 1'b1;
        if (gapDone) stateNext = PAD_CHECK;
      end
      PAD_FIN: begin
        strobe.restore = 1'b1;
        done           = 1'b1;
        stateNext      = PAD_IDLE;
      end
      default: stateNext = PAD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PAD_IDLE;
      errReg <= 1'b0;
    end else begin
      state  <= stateNext;
      errReg <= errNext;
    end
  end

  assign timedOut = errReg;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_valid_hold_r3: assert property (@(posedge clk) disable iff (rst)
    wordValid && !wordReady && !expired |=> wordValid);
  p_gap_after_word_r5: assert property (@(posedge clk) disable iff (rst)
    wordValid && wordReady |=> !wordValid);
endmodule

// File: rtl/pad_data.sv
module pad_data
  import pad_pkg::*;
#(
  parameter int RATIO_W        = 3,
  parameter int RATIO_ONE      = 0,
  parameter int DATA_W         = 32,
  parameter int CNT_W          = 16,
  parameter int GAP_CYCLES     = 4,
  parameter int TIMEOUT_CYCLES = 200_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  padStrobe_t         strobe,
  input  logic               wordValid,
  input  logic [RATIO_W-1:0] ratioIn,
  output logic [RATIO_W-1:0] ratioWr,
  output logic [DATA_W-1:0]  wordData,
  output logic [CNT_W-1:0]   padCount,
  output logic               expired,
  output logic               gapDone
);
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam logic [TMR_W-1:0]   TMO_LIMIT = TMR_W'(TIMEOUT_CYCLES);
  localparam logic [GAP_W-1:0]   GAP_LAST  = GAP_W'(GAP_CYCLES - 1);
  localparam logic [RATIO_W-1:0] ONE_CODE  = RATIO_W'(RATIO_ONE);

  logic [RATIO_W-1:0] ratioSaved;
  logic [TMR_W-1:0]   timer;
  logic [GAP_W-1:0]   gapCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ratioSaved <= '0;
      timer      <= '0;
      gapCnt     <= '0;
      padCount   <= '0;
    end else begin
      if (strobe.capture) begin
        ratioSaved <= ratioIn;
        timer      <= '0;
        padCount   <= '0;
      end else begin
        if (strobe.run && !expired) timer <= timer + 1'b1;
        if (strobe.countWord) padCount <= padCount + 1'b1;
      end
      gapCnt <= strobe.gapRun ? gapCnt + 1'b1 : '0;
    end
  end

  assign expired  = (timer == TMO_LIMIT);
  assign gapDone  = strobe.gapRun && (gapCnt == GAP_LAST);
  assign ratioWr  = strobe.restore ? ratioSaved : ONE_CODE;
  assign wordData = wordValid ? '1 : '0;

  p_count_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture && !strobe.countWord |=> $stable(padCount));
  p_timer_bounded_r6: assert property (@(posedge clk) disable iff (rst)
    timer <= TMO_LIMIT);
endmodule

// File: rtl/sync_pad_filler.sv
module sync_pad_filler
  import pad_pkg::*;
#(
  parameter int RATIO_W        = 3,
  parameter int RATIO_ONE      = 0,
  parameter int DATA_W         = 32,
  parameter int CNT_W          = 16,
  parameter int GAP_CYCLES     = 4,
  parameter int TIMEOUT_CYCLES = 200_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               done,
  output logic               timedOut,
  input  logic [RATIO_W-1:0] ratioIn,
  output logic [RATIO_W-1:0] ratioWr,
  output logic               ratioWrEn,
  output logic [DATA_W-1:0]  wordData,
  output logic               wordValid,
  input  logic               wordReady,
  input  logic               earlyUser,
  output logic [CNT_W-1:0]   padCount
);
  padStrobe_t strobe;
  logic expired, gapDone;

  pad_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .earlyUser(earlyUser),
    .wordReady(wordReady), .expired(expired), .gapDone(gapDone),
    .strobe(strobe), .wordValid(wordValid), .done(done), .timedOut(timedOut)
  );

  pad_data #(
    .RATIO_W(RATIO_W), .RATIO_ONE(RATIO_ONE), .DATA_W(DATA_W),
    .CNT_W(CNT_W), .GAP_CYCLES(GAP_CYCLES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_data (
    .clk(clk), .rst(rst), .strobe(strobe), .wordValid(wordValid),
    .ratioIn(ratioIn), .ratioWr(ratioWr), .wordData(wordData),
    .padCount(padCount), .expired(expired), .gapDone(gapDone)
  );

  assign ratioWrEn = strobe.capture | strobe.restore;

  p_restore_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> ratioWrEn);
  p_force_one_r2: assert property (@(posedge clk) disable iff (rst)
    ratioWrEn && !done |-> ratioWr == RATIO_W'(RATIO_ONE));
  p_stall_data_r3: assert property (@(posedge clk) disable iff (rst)
    wordValid && !wordReady && !expired |=> $stable(wordData));
endmodule

// File: tb/test_sync_pad_filler.sv
module test_sync_pad_filler;
  localparam int RW = 3, DW = 32, CW = 8, GAP = 3, TMO = 20;
  localparam logic [RW-1:0] ONE = '0, ORIG = 3'd5;

  logic clk = 0, rst = 1, start = 0, wordReady = 0, earlyUser = 0;
  logic done, timedOut, ratioWrEn, wordValid;
  logic [RW-1:0] ratioWr, ratioReg;
  logic [DW-1:0] wordData;
  logic [CW-1:0] padCount;
  int total = 0, bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  sync_pad_filler #(.RATIO_W(RW), .RATIO_ONE(0), .DATA_W(DW), .CNT_W(CW),
    .GAP_CYCLES(GAP), .TIMEOUT_CYCLES(TMO)) i_sync_pad_filler (
    .clk(clk), .rst(rst), .start(start), .done(done), .timedOut(timedOut),
    .ratioIn(ratioReg), .ratioWr(ratioWr), .ratioWrEn(ratioWrEn),
    .wordData(wordData), .wordValid(wordValid), .wordReady(wordReady),
    .earlyUser(earlyUser), .padCount(padCount));

  // ratio register model
  always @(posedge clk)
    if (rst) ratioReg <= ORIG;
    else if (ratioWrEn) ratioReg <= ratioWr;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check("R1 ratio forced to 1:1", ratioReg, ONE);
  endtask

  // runs until done; flag rises when padCount reaches flagAt (-1: never)
  // readyMode 0: always ready, 1: ready every third cycle, 2: never ready
  task automatic run(input int flagAt, input int readyMode, output int doneCyc,
                     output int badData, output int badRatio, output int gapErr,
                     output int stallErr);
    int cyc = 0, lastHs = -1;
    logic prevStall = 0;
    logic [DW-1:0] prevData = '0;
    badData = 0; badRatio = 0; gapErr = 0; stallErr = 0;
    while (!done && cyc < 300) begin
      if (flagAt >= 0 && padCount == CW'(flagAt)) earlyUser = 1;
      wordReady = (readyMode == 0) || (readyMode == 1 && cyc % 3 == 0);
      #0.5;
      if (prevStall && (!wordValid || wordData !== prevData)) stallErr++;
      if (wordValid && wordData !== '1) badData++;
      if (ratioReg !== ONE) badRatio++;
      if (wordValid && wordReady) begin
        if (readyMode == 0 && lastHs >= 0 && cyc - lastHs != GAP + 2) gapErr++;
        lastHs = cyc;
      end
      prevStall = wordValid && !wordReady;
      prevData = wordData;
      @(negedge clk);
      cyc++;
    end
    doneCyc = cyc;
  endtask

  task automatic after_done(input string tag, input logic expErr, input int expCnt);
    check({tag, " R9 err with done"}, timedOut, expErr);
    check({tag, " R8 count"}, padCount, expCnt);
    @(negedge clk);
    check({tag, " R9 done one cycle"}, done, 0);
    check({tag, " R7 ratio restored"}, ratioReg, ORIG);
    repeat (3) @(negedge clk);
    check({tag, " R8 count held"}, padCount, expCnt);
    earlyUser = 0; wordReady = 0;
  endtask

  task automatic t_reset();
    check("R10 done", done, 0);
    check("R10 valid", wordValid, 0);
    check("R10 count", padCount, 0);
    check("R10 ratio write", ratioWrEn, 0);
  endtask

  task automatic t_flag_early();
    int d, bd, br, ge, se;
    earlyUser = 1;
    kick();
    run(-1, 0, d, bd, br, ge, se);
    check("R4 done right after start", d, 1);
    after_done("early", 0, 0);
  endtask

  task automatic t_normal();
    int d, bd, br, ge, se;
    kick();
    run(2, 0, d, bd, br, ge, se);
    check("R3 all-ones data", bd, 0);
    check("R2 ratio held during pad", br, 0);
    check("R5 word spacing", ge, 0);
    check("R4 stops at next check", d, 11);
    after_done("normal", 0, 2);
  endtask

  task automatic t_backpressure();
    int d, bd, br, ge, se;
    kick();
    run(3, 1, d, bd, br, ge, se);
    check("R3 valid/data held under stall", se, 0);
    check("R3 all-ones data stalled", bd, 0);
    after_done("stall", 0, 3);
  endtask

  task automatic t_timeout();
    int d, bd, br, ge, se;
    kick();
    run(-1, 0, d, bd, br, ge, se);
    check("R6 timeout cycle", d, TMO + 1);
    after_done("timeout", 1, 4);
  endtask

  task automatic t_tie();
    int d, bd, br, ge, se;
    kick();
    run(4, 0, d, bd, br, ge, se);
    check("R6 tie done cycle", d, TMO + 1);
    after_done("tie flag wins R6", 0, 4);
  endtask

  task automatic t_stall_timeout();
    int d, bd, br, ge, se;
    kick();
    run(-1, 2, d, bd, br, ge, se);
    check("R6 stalled timeout cycle", d, TMO + 1);
    after_done("stalled R6", 1, 0);
  endtask

  task automatic t_reset_mid();
    kick();
    wordReady = 1;
    repeat (4) @(negedge clk);
    check("R8 count before reset", padCount, 1);
    rst = 1;
    @(negedge clk) rst = 0;
    check("R10 count after reset", padCount, 0);
    check("R10 valid after reset", wordValid, 0);
    repeat (3) @(negedge clk);
    check("R10 stays idle", wordValid, 0);
    wordReady = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_flag_early();
    t_normal();
    t_backpressure();
    t_timeout();
    t_tie();
    t_stall_timeout();
    t_reset_mid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule